// File: doc/BRIEF.md
# Sync-Referenced Active Window Positioner

This block sits on a graphics pixel stream that carries horizontal and vertical sync, and marks out a rectangular window of active video in it. It counts pixels from every rising edge of horizontal sync and lines from every rising edge of vertical sync. A programmable number of pixels and lines is skipped before the window opens, and a programmable width and height close it. Inside the window it passes the pixel data and reports the pixel's column and row relative to the window's top-left corner. Outside the window it drives zeros and holds the active flag low.

The window is tied to sync timing and not to any fixed line layout. Shifting the syncs therefore moves the picture even when the offsets are unchanged. Because pixel counting simply continues from the sync edge, a horizontal offset larger than the distance to the end of the line reaches into the start of the following line. The offset that places video at the left edge is the line total minus the sync position. Offset and size values are sampled at a vertical sync rising edge, so a frame never sees a half-updated window.

Top module: `wpos_top`

## Requirements
- R1: While reset is high, and on the first output after it, act_o is 0 and pix_o, x_o and y_o are all zero.
- R2: The pixel sampled in a cycle where hsync_i is high and was low in the previous cycle has horizontal index 0, and each later pixel's index is one higher. The window opens at index hoff. x_o equals index minus hoff, and all outputs show the result for a pixel one clock after it is sampled.
- R3: The window stays open for exactly hlen pixels of a line, so x_o runs from 0 to hlen-1 while act_o is high.
- R4: The pixel sampled on a vertical sync rising edge has line index 0. Each later hsync rising edge adds one, and a vertical rise wins over a horizontal rise that falls in the same cycle. Lines voff to voff+vlen-1 are active, and y_o equals line index minus voff.
- R5: Whenever act_o is 0, pix_o, x_o and y_o are 0. Whenever act_o is 1, pix_o equals the input pixel it belongs to.
- R6: Changes on hoff_i, hlen_i, voff_i and vlen_i have no effect until the next vertical sync rising edge. From the pixel sampled on that edge onward, the new values apply.
- R7: The horizontal index keeps counting past the end of the line until the next hsync rise. With hoff set to line total minus sync position, the first active pixel is the line's pixel 0. Moving the hsync position by k pixels moves the window by k pixels.
- R8: With hlen or vlen equal to zero, no pixel of the frame is active. Pixel and line indices stop at their all-ones value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, rising edge restarts pixel count |
| vsync_i | input | 1 | Vertical sync, rising edge restarts line count and loads settings |
| pix_i | input | DATA_W (24) | Input pixel data |
| hoff_i | input | PIX_W (12) | Pixels to skip after the hsync rise |
| hlen_i | input | PIX_W (12) | Window width in pixels |
| voff_i | input | LINE_W (11) | Lines to skip after the vsync rise |
| vlen_i | input | LINE_W (11) | Window height in lines |
| pix_o | output | DATA_W (24) | Gated pixel data, zero outside the window |
| act_o | output | 1 | High for pixels inside the window |
| x_o | output | PIX_W (12) | Column inside the window |
| y_o | output | LINE_W (11) | Row inside the window |

## Verification
A wrong pixel counter shows up as x_o stepping off by one, or as act_o opening a pixel early or late, on the very first line of the window. A wrong line counter or a wrong vertical-over-horizontal priority moves y_o and the window's first row, which becomes visible within one frame. A settings register that loads at the wrong moment changes the window shape in the frame where the settings were written, rather than in the next frame. A stale previous-sync value gives double or missed restarts, which break the x_o sequence at the next sync edge.

// File: rtl/wpos_pkg.sv
package wpos_pkg;

    parameter int unsigned PIX_W  = 12;
    parameter int unsigned LINE_W = 11;
    parameter int unsigned DATA_W = 24;
    localparam int unsigned CMP_W = 16;

    typedef struct packed {
        logic [PIX_W-1:0]  hoff;
        logic [PIX_W-1:0]  hlen;
        logic [LINE_W-1:0] voff;
        logic [LINE_W-1:0] vlen;
    } win_cfg_t;

    // true when idx lies in [start, start+len)
    function automatic logic span_hit(input logic [CMP_W-1:0] idx,
                                      input logic [CMP_W-1:0] start,
                                      input logic [CMP_W-1:0] len);
        return (idx >= start) && ((idx - start) < len);
    endfunction

endpackage

// File: rtl/wpos_edge.sv
module wpos_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R2: a detected rise can never repeat on the next cycle
    a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/wpos_counter.sv
module wpos_counter #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] idx_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_comb begin
        if (clr_i)                     idx_o = '0;
        else if (inc_i && cnt_q != TOP) idx_o = cnt_q + 1'b1;
        else                           idx_o = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= idx_o;
    end

    // R8: a saturated count stays put until cleared
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));
endmodule

// File: rtl/wpos_shadow.sv
module wpos_shadow
    import wpos_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  win_cfg_t cfg_i,
    output win_cfg_t eff_o,
    output win_cfg_t shd_o
);
    win_cfg_t shd_q;

    always_ff @(posedge clk) begin
        if (rst)         shd_q <= '0;
        else if (load_i) shd_q <= cfg_i;
    end

    assign eff_o = load_i ? cfg_i : shd_q;
    assign shd_o = shd_q;

    // R6: settings are frozen between vertical sync rises
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(shd_q));
endmodule

// File: rtl/wpos_top.sv
module wpos_top
    import wpos_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic [PIX_W-1:0]  hoff_i,
    input  logic [PIX_W-1:0]  hlen_i,
    input  logic [LINE_W-1:0] voff_i,
    input  logic [LINE_W-1:0] vlen_i,
    output logic [DATA_W-1:0] pix_o,
    output logic              act_o,
    output logic [PIX_W-1:0]  x_o,
    output logic [LINE_W-1:0] y_o
);
    localparam int unsigned N_SYNC = 2;

    logic [N_SYNC-1:0] sync_lvl;
    logic [N_SYNC-1:0] sync_rise;
    logic              hrise;
    logic              vrise;

    assign sync_lvl = {vsync_i, hsync_i};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_edge
        wpos_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (sync_lvl[g]),
            .rise_o (sync_rise[g])
        );
    end

    assign hrise = sync_rise[0];
    assign vrise = sync_rise[1];

    win_cfg_t cfg_in, eff, shd;
    assign cfg_in = '{hoff: hoff_i, hlen: hlen_i, voff: voff_i, vlen: vlen_i};

    wpos_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load_i (vrise),
        .cfg_i  (cfg_in),
        .eff_o  (eff),
        .shd_o  (shd)
    );

    logic [PIX_W-1:0]  pidx;
    logic [LINE_W-1:0] lidx;

    wpos_counter #(.W(PIX_W)) u_pix_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (hrise),
        .inc_i (1'b1),
        .idx_o (pidx)
    );

    wpos_counter #(.W(LINE_W)) u_line_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (vrise),
        .inc_i (hrise),
        .idx_o (lidx)
    );

    logic h_hit, v_hit, in_win;

    assign h_hit  = span_hit(CMP_W'(pidx), CMP_W'(eff.hoff), CMP_W'(eff.hlen));
    assign v_hit  = span_hit(CMP_W'(lidx), CMP_W'(eff.voff), CMP_W'(eff.vlen));
    assign in_win = h_hit & v_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o <= 1'b0;
            pix_o <= '0;
            x_o   <= '0;
            y_o   <= '0;
        end else begin
            act_o <= in_win;
            pix_o <= in_win ? pix_i : '0;
            x_o   <= in_win ? (pidx - eff.hoff) : '0;
            y_o   <= in_win ? (lidx - eff.voff) : '0;
        end
    end

    // R5: idle outputs are zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !act_o |-> (pix_o == '0 && x_o == '0 && y_o == '0));

    // R3: coordinates stay inside the loaded window size
    a_r3_x_bound: assert property (@(posedge clk) disable iff (rst)
        act_o |-> (x_o < shd.hlen && y_o < shd.vlen));

    // R2: a pixel on an hsync rise can only be active as column 0
    a_r2_hrestart: assert property (@(posedge clk) disable iff (rst)
        hrise |=> (!act_o || x_o == '0));

    // R4: a pixel on a vsync rise can only be active as row 0
    a_r4_vrestart: assert property (@(posedge clk) disable iff (rst)
        vrise |=> (!act_o || y_o == '0));
endmodule

// File: tb/tb_wpos_top.sv
module tb_wpos_top;
    import wpos_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PMAX = (1 << PIX_W) - 1;
    localparam int LMAX = (1 << LINE_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hsync_i = 1'b0;
    logic              vsync_i = 1'b0;
    logic [DATA_W-1:0] pix_i = '0;
    logic [PIX_W-1:0]  hoff_i = '0;
    logic [PIX_W-1:0]  hlen_i = '0;
    logic [LINE_W-1:0] voff_i = '0;
    logic [LINE_W-1:0] vlen_i = '0;
    logic [DATA_W-1:0] pix_o;
    logic              act_o;
    logic [PIX_W-1:0]  x_o;
    logic [LINE_W-1:0] y_o;

    wpos_top dut (
        .clk(clk), .rst(rst), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .pix_i(pix_i), .hoff_i(hoff_i), .hlen_i(hlen_i), .voff_i(voff_i),
        .vlen_i(vlen_i), .pix_o(pix_o), .act_o(act_o), .x_o(x_o), .y_o(y_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state derived from the requirements
    int m_hsp = 0, m_vsp = 0, m_pq = 0, m_lq = 0;
    int s_hoff = 0, s_hlen = 0, s_voff = 0, s_vlen = 0;
    int g_act_cnt = 0, g_first_p = -1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic bit hit(input int i, input int s, input int n);
        return (i >= s) && ((i - s) < n);
    endfunction

    task automatic step(input bit hs, input bit vs, input logic [DATA_W-1:0] d);
        int hr, vr, pi, li, ex, ey;
        bit ea;
        logic [DATA_W-1:0] ep;
        hsync_i = hs; vsync_i = vs; pix_i = d;
        @(posedge clk);
        hr = (hs && m_hsp == 0) ? 1 : 0;
        vr = (vs && m_vsp == 0) ? 1 : 0;
        m_hsp = hs; m_vsp = vs;
        pi = hr ? 0 : ((m_pq == PMAX) ? PMAX : m_pq + 1);
        li = vr ? 0 : (hr ? ((m_lq == LMAX) ? LMAX : m_lq + 1) : m_lq);
        m_pq = pi; m_lq = li;
        if (vr) begin
            s_hoff = hoff_i; s_hlen = hlen_i; s_voff = voff_i; s_vlen = vlen_i;
        end
        ea = hit(pi, s_hoff, s_hlen) && hit(li, s_voff, s_vlen);
        ep = ea ? d : '0;
        ex = ea ? pi - s_hoff : 0;
        ey = ea ? li - s_voff : 0;
        @(negedge clk);
        chk(act_o == ea, ea ? "R3" : "R5", "act", int'(act_o), int'(ea));
        chk(pix_o == ep, ea ? "R2" : "R5", "pix", int'(pix_o), int'(ep));
        chk(int'(x_o) == ex, "R2", "x", int'(x_o), ex);
        chk(int'(y_o) == ey, "R4", "y", int'(y_o), ey);
    endtask

    // one frame; zap clears hlen_i right after the frame starts
    task automatic frame(input int htot, input int hpos, input int vtot, input bit zap);
        g_act_cnt = 0; g_first_p = -1;
        for (int l = 0; l < vtot; l++) begin
            for (int p = 0; p < htot; p++) begin
                if (zap && l == 1 && p == 0) hlen_i = '0;
                step((p >= hpos) && (p < hpos + 3), (l < 2), DATA_W'($urandom));
                if (act_o) begin
                    if (g_first_p < 0) g_first_p = p;
                    g_act_cnt++;
                end
            end
        end
    endtask

    task automatic set_cfg(input int ho, input int hl, input int vo, input int vl);
        hoff_i = PIX_W'(ho); hlen_i = PIX_W'(hl);
        voff_i = LINE_W'(vo); vlen_i = LINE_W'(vl);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        set_cfg(3, 5, 1, 2);
        repeat (3) @(negedge clk);
        // R1: outputs idle while in reset
        chk(act_o == 1'b0, "R1", "act in reset", int'(act_o), 0);
        chk(pix_o == '0 && x_o == '0 && y_o == '0, "R1", "data in reset",
            int'(pix_o), 0);
        rst = 1'b0;
        step(1'b0, 1'b0, 24'hABCDEF);
        chk(act_o == 1'b0, "R1", "first output", int'(act_o), 0);

        // R7: left-edge alignment and sync-follow
        set_cfg(40 - 30, 8, 3, 4);
        frame(40, 30, 20, 1'b0);
        frame(40, 30, 20, 1'b0);
        chk(g_first_p == 0, "R7", "first active pixel", g_first_p, 0);
        chk(g_act_cnt == 32, "R3", "active count", g_act_cnt, 32);
        frame(40, 26, 20, 1'b0);
        chk(g_first_p == 36, "R7", "moved sync first pixel", g_first_p, 36);

        // R6: mid-frame change waits for next vsync rise; R8 zero width
        frame(40, 26, 20, 1'b1);
        chk(g_act_cnt > 0, "R6", "old cfg still active", g_act_cnt, 32);
        frame(40, 26, 20, 1'b0);
        chk(g_act_cnt == 0, "R8", "zero width", g_act_cnt, 0);
        set_cfg(2, 6, 0, 0);
        frame(40, 26, 20, 1'b0);
        frame(40, 26, 20, 1'b0);
        chk(g_act_cnt == 0, "R8", "zero height", g_act_cnt, 0);

        // R4: vertical offset zero with hoff zero puts row 0 at the vsync rise
        set_cfg(0, 4, 0, 3);
        frame(30, 0, 16, 1'b0);
        frame(30, 0, 16, 1'b0);
        chk(g_first_p == 0, "R4", "row 0 at frame start", g_first_p, 0);

        // random frames checked against the reference state
        for (int f = 0; f < 8; f++) begin
            int ht, hp;
            ht = 36 + int'($urandom % 20);
            hp = int'($urandom % (ht - 4));
            set_cfg(int'($urandom % 50), int'($urandom % 40),
                    int'($urandom % 18), int'($urandom % 18));
            frame(ht, hp, 22 + int'($urandom % 6), 1'b0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule